// File: doc/BRIEF.md
# Radio Transceiver Power-Up Sequencer

This block brings an external radio transceiver from power-on to a usable state. After a system reset, or when a restart is requested, it holds the transceiver's active-low hardware reset pin low for a set time. It then releases the pin and waits a second set time. After that it issues a fixed, ordered list of register writes through a register access port. The port carries a long/short address flag, an address, write data, a one-cycle start strobe and a one-cycle done strobe back from the port. The sequencer issues one write and waits for its done before it issues the next. The list starts and ends with a two-write reset of the radio's internal state machine. Between those it programs the network identity bytes, flushes the receive buffer, sets the synthesizer, power, filter and oscillator controls, the channel-assessment settings and the default channel, and turns off receive address filtering.

A channel-change request writes the channel register, pulses the radio state machine reset, and then waits a long settle time. `ready` is high only when no sequence is running. A channel request that arrives while the block is busy is kept and served as soon as `ready` rises. All wait lengths are parameters counted in clock cycles.

Top module: `xcvr_powerup_seq`

## Requirements
- R1: After `rst_n` is released, `hw_reset_n` is low for exactly RST_LOW_CYC clock cycles. While `rst_n` is low, `hw_reset_n`, `ready` and `acc_start` are all low.
- R2: `hw_reset_n` stays high for exactly RST_WAIT_CYC cycles before the first `acc_start` of a full sequence, and `acc_start` is never high while `hw_reset_n` is low.
- R3: A full sequence issues exactly these 18 writes, in this order, each shown as (long flag, 10-bit address, data): (0,036,04) (0,036,00) (0,001,AA) (0,002,AA) (0,003,AA) (0,004,AA) (0,00D,01) (1,202,80) (1,203,00) (1,206,80) (1,208,10) (0,03A,78) (0,03E,40) (0,03F,00) (1,200,00) (0,000,01) (0,036,04) (0,036,00). All values are hex, and the long flag is 1 for a long-address write.
- R4: `acc_start` is a one-cycle pulse. No new start is issued until `acc_done` has answered the previous one. `acc_long`, `acc_addr` and `acc_data` hold steady from the start until the done.
- R5: An `acc_done` pulse that does not answer an outstanding access is ignored: no start follows it and `ready` does not change.
- R6: `ready` is low from the first cycle of any sequence until it ends. After the last write of a full sequence, `ready` rises in the cycle after the cycle in which `acc_done` is high.
- R7: A channel change issues three writes, in order: (1,200,{chan_num[3:0],4'h3}), (0,036,04), (0,036,00).
- R8: After the last write of a channel change, `ready` rises SETTLE_CYC+1 cycles after the cycle in which `acc_done` is high.
- R9: A `chan_req` seen while `ready` is low, or in the same cycle as an accepted `restart_req`, is held pending with the most recent `chan_num`. When `ready` next rises it stays high for exactly one cycle, and then the pending channel change runs.
- R10: A `restart_req` while `ready` is high reruns R1 to R3 and takes priority over a `chan_req` in the same cycle. A `restart_req` while `ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| restart_req | input | 1 | One-cycle request to rerun the full power-up sequence |
| chan_req | input | 1 | One-cycle request for a channel change |
| chan_num | input | 4 | Channel number for the change, sampled with `chan_req` |
| acc_done | input | 1 | One-cycle completion strobe from the register access port |
| hw_reset_n | output | 1 | Active-low hardware reset pin of the transceiver |
| acc_start | output | 1 | One-cycle start strobe to the register access port |
| acc_long | output | 1 | 1 selects a long-address write, 0 a short-address write |
| acc_addr | output | 10 | Register address of the current write |
| acc_data | output | 8 | Data of the current write |
| ready | output | 1 | High when no sequence is running |

## Verification
Every interval is counted on falling-edge samples, so the bench never has to line up with a rising edge. After `rst_n` rises there are RST_LOW_CYC low samples of `hw_reset_n`, then RST_WAIT_CYC high samples before the first start. `ready` is sampled one cycle after the final done of a full sequence and SETTLE_CYC+1 cycles after the final done of a channel change. The bench's access-port model answers each start after a chosen latency, logs every write, and flags any start that comes before the done or any change of address or data while an access is outstanding. Pending-request timing is checked by recording, at each start, how many `ready` samples have been seen, which shows the single high cycle between two sequences.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int BOOT_LEN = 18;
  localparam int CHAN_LEN = 3;
  localparam int STEP_W   = $clog2(BOOT_LEN);

  typedef struct packed {
    logic              is_long;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reg_wr_t;

  function automatic reg_wr_t mk(input logic lng, input logic [ADDR_W-1:0] a,
                                 input logic [DATA_W-1:0] d);
    reg_wr_t r;
    r.is_long = lng;
    r.addr    = a;
    r.data    = d;
    return r;
  endfunction

  // Channel register word: channel in the upper nibble, fixed 0x3 below.
  function automatic logic [DATA_W-1:0] chan_word(input logic [3:0] ch);
    return {ch, 4'h3};
  endfunction

  function automatic reg_wr_t boot_step(input logic [STEP_W-1:0] i);
    case (i)
      5'd0:  return mk(1'b0, 10'h036, 8'h04);
      5'd1:  return mk(1'b0, 10'h036, 8'h00);
      5'd2:  return mk(1'b0, 10'h001, 8'hAA);
      5'd3:  return mk(1'b0, 10'h002, 8'hAA);
      5'd4:  return mk(1'b0, 10'h003, 8'hAA);
      5'd5:  return mk(1'b0, 10'h004, 8'hAA);
      5'd6:  return mk(1'b0, 10'h00D, 8'h01);
      5'd7:  return mk(1'b1, 10'h202, 8'h80);
      5'd8:  return mk(1'b1, 10'h203, 8'h00);
      5'd9:  return mk(1'b1, 10'h206, 8'h80);
      5'd10: return mk(1'b1, 10'h208, 8'h10);
      5'd11: return mk(1'b0, 10'h03A, 8'h78);
      5'd12: return mk(1'b0, 10'h03E, 8'h40);
      5'd13: return mk(1'b0, 10'h03F, 8'h00);
      5'd14: return mk(1'b1, 10'h200, 8'h00);
      5'd15: return mk(1'b0, 10'h000, 8'h01);
      5'd16: return mk(1'b0, 10'h036, 8'h04);
      default: return mk(1'b0, 10'h036, 8'h00);
    endcase
  endfunction

  function automatic reg_wr_t chan_step(input logic [STEP_W-1:0] i,
                                        input logic [3:0] ch);
    case (i)
      5'd0:    return mk(1'b1, 10'h200, chan_word(ch));
      5'd1:    return mk(1'b0, 10'h036, 8'h04);
      default: return mk(1'b0, 10'h036, 8'h00);
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int W    = 16,
  parameter int INIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= W'(INIT);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt == W'(1));

  // A terminal count is seen for one cycle only unless reloaded.
  p_last_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load) |=> !last_o);

endmodule

// File: rtl/pwrseq_rom.sv
module pwrseq_rom
  import pwrseq_pkg::*;
(
  input  logic              seq_chan,
  input  logic [STEP_W-1:0] step_idx,
  input  logic [3:0]        cur_ch,
  output reg_wr_t           step_o,
  output logic              seq_last
);
  always_comb begin
    if (seq_chan) step_o = chan_step(step_idx, cur_ch);
    else          step_o = boot_step(step_idx);
  end

  assign seq_last = seq_chan ? (step_idx == STEP_W'(CHAN_LEN - 1))
                             : (step_idx == STEP_W'(BOOT_LEN - 1));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int RST_LOW_CYC  = 10000,
  parameter int RST_WAIT_CYC = 10000,
  parameter int SETTLE_CYC   = 50000000,
  parameter int TMR_W        = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_req,
  input  logic              chan_req,
  input  logic [3:0]        chan_num,
  input  logic              acc_done,
  input  logic              tmr_last,
  input  logic              seq_last,
  input  reg_wr_t           cur_step,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic [STEP_W-1:0] step_idx,
  output logic              seq_chan,
  output logic [3:0]        cur_ch,
  output logic              acc_start,
  output logic              hw_reset_n,
  output logic              ready
);
  typedef enum logic [2:0] {
    ST_RST_LOW, ST_RST_WAIT, ST_ISSUE, ST_WAIT, ST_SETTLE, ST_IDLE
  } st_t;

  st_t        state;
  logic       pend;
  logic [3:0] pend_ch;

  // Named internal events.
  logic step_ack, seq_done, restart_go, chan_go, chan_hold;
  assign step_ack   = (state == ST_WAIT) && acc_done;
  assign seq_done   = step_ack && seq_last;
  assign restart_go = (state == ST_IDLE) && restart_req;
  assign chan_go    = (state == ST_IDLE) && !restart_req && (chan_req || pend);
  assign chan_hold  = chan_req && ((state != ST_IDLE) || restart_req);

  assign acc_start  = (state == ST_ISSUE);
  assign hw_reset_n = (state != ST_RST_LOW);
  assign ready      = (state == ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(RST_LOW_CYC);
    if (restart_go) begin
      tmr_load = 1'b1;
    end else if (state == ST_RST_LOW && tmr_last) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(RST_WAIT_CYC);
    end else if (seq_done && seq_chan) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(SETTLE_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RST_LOW;
      step_idx <= '0;
      seq_chan <= 1'b0;
      cur_ch   <= '0;
      pend     <= 1'b0;
      pend_ch  <= '0;
    end else begin
      if (chan_hold) begin
        pend    <= 1'b1;
        pend_ch <= chan_num;
      end
      case (state)
        ST_RST_LOW:  if (tmr_last) state <= ST_RST_WAIT;
        ST_RST_WAIT: if (tmr_last) begin
          state    <= ST_ISSUE;
          step_idx <= '0;
          seq_chan <= 1'b0;
        end
        ST_ISSUE:    state <= ST_WAIT;
        ST_WAIT:     if (step_ack) begin
          if (!seq_last) begin
            step_idx <= step_idx + 1'b1;
            state    <= ST_ISSUE;
          end else if (seq_chan) begin
            state <= ST_SETTLE;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SETTLE:   if (tmr_last) state <= ST_IDLE;
        default: begin
          if (restart_go) begin
            state <= ST_RST_LOW;
          end else if (chan_go) begin
            state    <= ST_ISSUE;
            step_idx <= '0;
            seq_chan <= 1'b1;
            cur_ch   <= chan_req ? chan_num : pend_ch;
            pend     <= 1'b0;
          end
        end
      endcase
    end
  end

  // R2: the port is never started while the transceiver is held in reset.
  p_start_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> hw_reset_n);
  // R4: start is a single-cycle strobe.
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_start);
  // R4: the write presented to the port is steady while it is outstanding.
  p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start || (state == ST_WAIT && !acc_done)) |=> $stable(cur_step));
  // R5: the step counter moves forward only on an answered access.
  p_idx_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != $past(step_idx) && step_idx != '0) |-> $past(acc_done));
  // R6: no access is started while ready is shown.
  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !acc_start);
  // R9: a pending channel change leaves ready high for one cycle only.
  p_pend_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pend) |=> !ready);
  // R10: an accepted restart puts the pin in reset on the next cycle.
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && restart_req) |=> !hw_reset_n);

endmodule

// File: rtl/xcvr_powerup_seq.sv
module xcvr_powerup_seq
  import pwrseq_pkg::*;
#(
  parameter int RST_LOW_CYC  = 10000,
  parameter int RST_WAIT_CYC = 10000,
  parameter int SETTLE_CYC   = 50000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_req,
  input  logic              chan_req,
  input  logic [3:0]        chan_num,
  input  logic              acc_done,
  output logic              hw_reset_n,
  output logic              acc_start,
  output logic              acc_long,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              ready
);
  localparam int TMR_MAX = max3(RST_LOW_CYC, RST_WAIT_CYC, SETTLE_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic              tmr_load, tmr_last, seq_last, seq_chan;
  logic [TMR_W-1:0]  tmr_val;
  logic [STEP_W-1:0] step_idx;
  logic [3:0]        cur_ch;
  reg_wr_t           cur_step;

  pwrseq_timer #(.W(TMR_W), .INIT(RST_LOW_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .last_o(tmr_last)
  );

  pwrseq_rom u_rom (
    .seq_chan(seq_chan), .step_idx(step_idx), .cur_ch(cur_ch),
    .step_o(cur_step), .seq_last(seq_last)
  );

  pwrseq_ctrl #(
    .RST_LOW_CYC(RST_LOW_CYC), .RST_WAIT_CYC(RST_WAIT_CYC),
    .SETTLE_CYC(SETTLE_CYC), .TMR_W(TMR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart_req(restart_req),
    .chan_req(chan_req), .chan_num(chan_num), .acc_done(acc_done),
    .tmr_last(tmr_last), .seq_last(seq_last), .cur_step(cur_step),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .step_idx(step_idx),
    .seq_chan(seq_chan), .cur_ch(cur_ch), .acc_start(acc_start),
    .hw_reset_n(hw_reset_n), .ready(ready)
  );

  assign acc_long = cur_step.is_long;
  assign acc_addr = cur_step.addr;
  assign acc_data = cur_step.data;

endmodule

// File: tb/xcvr_powerup_seq_tb.sv
`timescale 1ns/1ps
module xcvr_powerup_seq_tb_top;
  localparam int NLOW = 12, NWAIT = 7, NSET = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic restart_req = 1'b0, chan_req = 1'b0, stray_done = 1'b0, resp_done = 1'b0;
  logic [3:0] chan_num = '0;
  logic acc_done, hw_reset_n, acc_start, acc_long, ready;
  logic [9:0] acc_addr;
  logic [7:0] acc_data;

  assign acc_done = resp_done | stray_done;
  always #5 clk = ~clk;

  xcvr_powerup_seq #(.RST_LOW_CYC(NLOW), .RST_WAIT_CYC(NWAIT), .SETTLE_CYC(NSET))
  dut_i (
    .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .chan_req(chan_req),
    .chan_num(chan_num), .acc_done(acc_done), .hw_reset_n(hw_reset_n),
    .acc_start(acc_start), .acc_long(acc_long), .acc_addr(acc_addr),
    .acc_data(acc_data), .ready(ready)
  );

  int checks = 0, errors = 0;
  // Monitor state.
  int cyc = 0, lat = 1, cd = 0, log_n = 0;
  logic [18:0] log_w [64];
  int rdy_at [64];
  int hw_low = 0, pre_start = 0, viol = 0, rdy_hi = 0, rdy_rise = 0;
  int last_done_cyc = 0, rise_cyc = 0;
  logic seen_low = 0, started = 0, prev_rdy = 0;
  // Expected writes.
  logic [18:0] exp_w [64];
  int exp_n = 0;

  task automatic chk(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      resp_done = 0; cd = 0; prev_rdy = 0;
    end else begin
      if (resp_done) resp_done = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin resp_done = 1; last_done_cyc = cyc; end
        else if (acc_start) viol++;
        else if ({acc_long, acc_addr, acc_data} != log_w[log_n-1]) viol++;
      end
      if (acc_start && !hw_reset_n) viol++;
      if (!hw_reset_n) begin hw_low++; seen_low = 1; end
      else if (seen_low && !started && !acc_start) pre_start++;
      if (acc_start) begin
        if (cd > 0 || resp_done) viol++;
        started = 1;
        if (log_n < 64) begin
          log_w[log_n] = {acc_long, acc_addr, acc_data};
          rdy_at[log_n] = rdy_hi;
          log_n++;
        end
        cd = lat;
      end
      if (ready) rdy_hi++;
      if (ready && !prev_rdy) begin rdy_rise++; rise_cyc = cyc; end
      prev_rdy = ready;
    end
  end

  task automatic clear_mon();
    log_n = 0; hw_low = 0; pre_start = 0; viol = 0; rdy_hi = 0;
    seen_low = 0; started = 0;
  endtask

  task automatic push(logic l, logic [9:0] a, logic [7:0] d);
    exp_w[exp_n] = {l, a, d};
    exp_n++;
  endtask

  task automatic push_boot();
    push(0, 10'h036, 8'h04); push(0, 10'h036, 8'h00);
    for (int k = 1; k <= 4; k++) push(0, 10'(k), 8'hAA);
    push(0, 10'h00D, 8'h01);
    push(1, 10'h202, 8'h80); push(1, 10'h203, 8'h00);
    push(1, 10'h206, 8'h80); push(1, 10'h208, 8'h10);
    push(0, 10'h03A, 8'h78); push(0, 10'h03E, 8'h40); push(0, 10'h03F, 8'h00);
    push(1, 10'h200, 8'h00); push(0, 10'h000, 8'h01);
    push(0, 10'h036, 8'h04); push(0, 10'h036, 8'h00);
  endtask

  task automatic push_chan(int ch);
    push(1, 10'h200, 8'((ch % 16) * 16 + 3));
    push(0, 10'h036, 8'h04); push(0, 10'h036, 8'h00);
  endtask

  task automatic cmp_log(string req);
    chk(req, log_n, exp_n, "write count");
    for (int k = 0; k < exp_n && k < log_n; k++)
      chk(req, int'(log_w[k]), int'(exp_w[k]), $sformatf("write %0d", k));
  endtask

  task automatic wait_rise(int prev, int limit);
    int n = 0;
    while (rdy_rise == prev && n < limit) begin @(negedge clk); n++; end
    if (rdy_rise == prev) chk("R6", 0, 1, "ready rise timeout");
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #2 sig = 1;
    @(negedge clk); #1 clear_mon();
    @(posedge clk); #2 sig = 0;
  endtask

  task automatic t_reset_boot();
    int r0;
    rst_n = 0; lat = 1;
    repeat (3) @(negedge clk);
    chk("R1", {hw_reset_n, ready, acc_start}, 0, "outputs in reset");
    clear_mon(); exp_n = 0; push_boot();
    r0 = rdy_rise;
    @(posedge clk); #2 rst_n = 1;
    wait_rise(r0, 2000);
    chk("R1", hw_low, NLOW, "reset pin low cycles");
    chk("R2", pre_start, NWAIT, "release-to-start cycles");
    cmp_log("R3");
    chk("R4", viol, 0, "handshake violations");
    chk("R6", rise_cyc - last_done_cyc, 1, "done-to-ready (boot)");
    chk("R6", rdy_at[log_n-1], 0, "ready seen during boot");
  endtask

  task automatic t_stray_done();
    int n0 = log_n;
    @(posedge clk); #2 stray_done = 1;
    @(posedge clk); #2 stray_done = 0;
    repeat (5) @(negedge clk);
    chk("R5", log_n, n0, "start after stray done");
    chk("R5", ready, 1, "ready after stray done");
  endtask

  task automatic t_channel(int ch, int l);
    int r0 = rdy_rise;
    lat = l; exp_n = 0; push_chan(ch);
    chan_num = 4'(ch);
    pulse(chan_req);
    wait_rise(r0, 2000);
    cmp_log("R7");
    chk("R8", rise_cyc - last_done_cyc, NSET + 1, "done-to-ready (channel)");
    chk("R6", rdy_at[2], 0, "ready seen during channel change");
    chk("R4", viol, 0, "handshake violations (channel)");
  endtask

  task automatic t_busy_restart();
    int r0 = rdy_rise;
    lat = 4; exp_n = 0; push_chan(11);
    chan_num = 4'd11;
    pulse(chan_req);
    repeat (3) @(negedge clk);
    @(posedge clk); #2 restart_req = 1;
    @(posedge clk); #2 restart_req = 0;
    wait_rise(r0, 2000);
    chk("R10", hw_low, 0, "reset pin after busy restart");
    cmp_log("R10");
  endtask

  task automatic t_pending();
    int r0 = rdy_rise, r1;
    lat = 2; exp_n = 0; push_boot(); push_chan(15);
    @(posedge clk); #2 restart_req = 1; chan_req = 1; chan_num = 4'd5;
    @(negedge clk); #1 clear_mon();
    @(posedge clk); #2 restart_req = 0; chan_req = 0;
    repeat (30) @(negedge clk);
    @(posedge clk); #2 chan_req = 1; chan_num = 4'd15;
    @(posedge clk); #2 chan_req = 0; chan_num = 4'd0;
    wait_rise(r0, 2000);
    r1 = rdy_rise;
    wait_rise(r1, 2000);
    chk("R10", hw_low, NLOW, "reset pin low cycles on restart");
    chk("R10", pre_start, NWAIT, "release-to-start on restart");
    cmp_log("R9");
    chk("R9", rdy_at[18], 1, "ready cycles before pending change");
    chk("R9", rdy_at[17], 0, "ready before boot end");
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: R6 ready never returned");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_boot();
    t_stray_done();
    t_channel(10, 3);
    t_channel(0, 1);
    t_channel(15, 2);
    t_busy_restart();
    t_pending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule